// File: doc/BRIEF.md
# SCSI Initiator Host Register Interface

This block is the byte-wide register port through which a host processor controls a simple SCSI initiator controller. The host presents an address, a one-cycle read or write strobe and a data byte. The address is shifted right by a configurable stride, and the low four bits of the result select one of sixteen byte registers. Several addresses have separate read and write copies. A write updates the write copy, and a read returns the read copy, which the block or a companion command sequencer maintains.

The block holds a 16-byte FIFO for programmed I/O and keeps the status, interrupt, sequence-step, configuration and identification registers. Some reads have side effects: popping the FIFO, and acknowledging the interrupt. A host write to the command register is forwarded to an external command sequencer as a one-cycle strobe. The sequencer returns new status, interrupt and sequence-step values through an update port and can request an interrupt. The block drives a single level interrupt line that mirrors bit 7 of the status register.

Top module: `scsi_hostif`

## Requirements
- R1: The register index is the low four bits of `bus_addr >> addr_shift`. Address bits below the stride do not change which register is accessed.
- R2: After reset every register reads 0x00, except index 8, which reads 0x07, and index 14, which reads 0x04. `irq` is low after reset.
- R3: A read of index 5 returns the value the register held before the read. The same access then clears index 5, clears status (index 4) bit 4, loads index 6 with 0x04 and clears status bit 7, which drops `irq`.
- R4: A write to index 0 or index 1 clears status bit 4 and updates only the write copy. A command write (index 3) with data bit 7 set copies the write copies of indexes 0 and 1 into their read copies.
- R5: The FIFO holds bytes written to index 2. A write that finds 15 bytes already stored is discarded, and `fifo_overrun` is high for the one cycle after that write.
- R6: A read of index 2 while the FIFO holds data returns the oldest byte, removes it and sets status bit 7, so `irq` goes high.
- R7: A read of index 2 while the FIFO is empty returns the byte last removed and changes nothing. Once the FIFO drains to empty, its storage restarts from the first slot without losing order.
- R8: Indexes 8 and 11 to 15 read back the last value written to them. Writes to indexes 4 to 7, 9 and 10 leave what those indexes read unchanged.
- R9: A write to index 3 stores the byte as the readable command value. `cmd_stb` is high for the one cycle after that write, with `cmd_code` equal to the byte.
- R10: While `seq_upd` is high, status bits 6 to 0 load from `seq_status`, index 5 loads from `seq_intr` and index 6 loads from `seq_step`. If `seq_raise` is also high, status bit 7 is set.
- R11: `irq` always equals status bit 7. It rises only after a FIFO pop or a raise request, and it falls only after a read of index 5.
- R12: `rdata` changes only in the cycle after a read strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (8) | Host byte address |
| addr_shift | input | SW (2) | Right shift applied to the address before decode |
| rd_stb | input | 1 | One-cycle read strobe; takes precedence over a write in the same cycle |
| wr_stb | input | 1 | One-cycle write strobe |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Read result, valid from the cycle after `rd_stb` |
| irq | output | 1 | Level interrupt request |
| fifo_overrun | output | 1 | Pulse: a FIFO write was refused |
| cmd_stb | output | 1 | Pulse to the sequencer: command byte written |
| cmd_code | output | 8 | Command byte that accompanies `cmd_stb` |
| seq_upd | input | 1 | Sequencer status update enable |
| seq_status | input | 7 | New status bits 6 to 0 |
| seq_intr | input | 8 | New interrupt register value |
| seq_step | input | 8 | New sequence-step value |
| seq_raise | input | 1 | Set status bit 7 (with `seq_upd`) |

## Verification
A stale interrupt bit shows at `irq` in the first cycle after the access that should have changed it. A clear-on-read that misses the status or step registers shows on the next read of those indexes. A FIFO pointer error shows as a byte out of order, or a wrong overrun pulse, on the next pop or on the sixteenth write. A count that does not reset on empty shows later, when the FIFO drains and refills. Wrong decode under a nonzero stride returns another register's contents on the same read, so the bench varies the stride and the ignored low address bits on every random access and compares every read against a model kept in the bench.

// File: rtl/scsi_hostif_pkg.sv
package scsi_hostif_pkg;
  localparam int NREG = 16;
  localparam int IXW  = 4;

  localparam logic [IXW-1:0] IX_CNT_LO  = 4'd0;
  localparam logic [IXW-1:0] IX_CNT_MID = 4'd1;
  localparam logic [IXW-1:0] IX_FIFO    = 4'd2;
  localparam logic [IXW-1:0] IX_CMD     = 4'd3;
  localparam logic [IXW-1:0] IX_STAT    = 4'd4;
  localparam logic [IXW-1:0] IX_INTR    = 4'd5;
  localparam logic [IXW-1:0] IX_STEP    = 4'd6;
  localparam logic [IXW-1:0] IX_CFG1    = 4'd8;
  localparam logic [IXW-1:0] IX_CHIPID  = 4'd14;

  localparam int ST_IRQ     = 7;  // status bit: interrupt pending
  localparam int ST_TCZ     = 4;  // status bit: transfer count zero
  localparam int CMD_RELOAD = 7;  // command bit: reload count read copies

  localparam logic [7:0] STEP_ON_ACK = 8'h04;
  localparam logic [7:0] CFG1_INIT   = 8'h07;
  localparam logic [7:0] CHIPID_INIT = 8'h04;

  // Register index from a byte address and a stride.
  function automatic logic [IXW-1:0] reg_index(input logic [15:0] a, input logic [3:0] sh);
    logic [15:0] t;
    t = a >> sh;
    return t[IXW-1:0];
  endfunction

  // Registers whose read copy follows host writes directly.
  function automatic logic echoes_write(input logic [IXW-1:0] ix);
    return (ix == IX_CFG1) || (ix >= 4'd11);
  endfunction

  // Read-copy value after reset.
  function automatic logic [7:0] reset_value(input logic [IXW-1:0] ix);
    if (ix == IX_CFG1)   return CFG1_INIT;
    if (ix == IX_CHIPID) return CHIPID_INIT;
    return 8'h00;
  endfunction
endpackage

// File: rtl/hostif_decode.sv
module hostif_decode
  import scsi_hostif_pkg::*;
#(
  parameter int AW = 8,
  parameter int SW = 2
) (
  input  logic [AW-1:0]  bus_addr,
  input  logic [SW-1:0]  addr_shift,
  input  logic           rd_stb,
  input  logic           wr_stb,
  output logic [IXW-1:0] idx,
  output logic           rd_ev,
  output logic           wr_ev
);
  assign idx   = reg_index(16'(bus_addr), 4'(addr_shift));
  assign rd_ev = rd_stb;
  assign wr_ev = wr_stb && !rd_stb;
endmodule

// File: rtl/hostif_fifo.sv
module hostif_fifo #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_req,
  input  logic                       pop_req,
  input  logic [7:0]                 din,
  output logic [7:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                       popped,
  output logic                       overrun
);
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH+1);
  localparam int LIMIT = DEPTH - 1;

  logic [DEPTH-1:0][7:0] mem_q;
  logic [PW-1:0]         rptr_q, wptr_q;
  logic [CW-1:0]         cnt_q, cnt_n;
  logic                  push_ok, pop_ok, ovr_q;

  assign push_ok = push_req && (cnt_q != CW'(LIMIT));
  assign pop_ok  = pop_req && (cnt_q != '0);
  assign cnt_n   = cnt_q + CW'(push_ok) - CW'(pop_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      ovr_q <= push_req && !push_ok;
      cnt_q <= cnt_n;
      if (cnt_n == '0) begin
        rptr_q <= '0;
        wptr_q <= '0;
      end else begin
        if (push_ok) wptr_q <= wptr_q + 1'b1;
        if (pop_ok)  rptr_q <= rptr_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                            mem_q[g] <= 8'h00;
      else if (push_ok && wptr_q == PW'(g))  mem_q[g] <= din;
    end
  end

  assign dout    = mem_q[rptr_q];
  assign cnt     = cnt_q;
  assign popped  = pop_ok;
  assign overrun = ovr_q;
endmodule

// File: rtl/hostif_regs.sv
module hostif_regs
  import scsi_hostif_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IXW-1:0] idx,
  input  logic           rd_ev,
  input  logic           wr_ev,
  input  logic [7:0]     wdata,
  input  logic           pop_ev,
  input  logic [7:0]     fifo_dout,
  input  logic           upd_en,
  input  logic [6:0]     upd_status,
  input  logic [7:0]     upd_intr,
  input  logic [7:0]     upd_step,
  input  logic           upd_raise,
  output logic [7:0]     rdata,
  output logic           stat_irq,
  output logic           ack_ev,
  output logic           cmd_stb,
  output logic [7:0]     cmd_code
);
  logic [NREG-1:0][7:0] rd_q, rd_n;   // read copies
  logic [NREG-1:0][7:0] wr_q, wr_n;   // write copies
  logic [7:0]           rdata_q, cmd_code_q;
  logic                 cmd_stb_q;

  assign ack_ev = rd_ev && (idx == IX_INTR);

  always_comb begin
    rd_n = rd_q;
    wr_n = wr_q;
    if (wr_ev) begin
      wr_n[idx] = wdata;
      if (idx == IX_CNT_LO || idx == IX_CNT_MID) rd_n[IX_STAT][ST_TCZ] = 1'b0;
      if (idx == IX_CMD) begin
        rd_n[IX_CMD] = wdata;
        if (wdata[CMD_RELOAD]) begin
          rd_n[IX_CNT_LO]  = wr_q[IX_CNT_LO];
          rd_n[IX_CNT_MID] = wr_q[IX_CNT_MID];
        end
      end
      if (echoes_write(idx)) rd_n[idx] = wdata;
    end
    if (pop_ev) begin
      rd_n[IX_FIFO]         = fifo_dout;
      rd_n[IX_STAT][ST_IRQ] = 1'b1;
    end
    if (ack_ev) begin
      rd_n[IX_INTR]         = 8'h00;
      rd_n[IX_STAT][ST_TCZ] = 1'b0;
      rd_n[IX_STAT][ST_IRQ] = 1'b0;
      rd_n[IX_STEP]         = STEP_ON_ACK;
    end
    if (upd_en) begin
      rd_n[IX_STAT][6:0] = upd_status;
      if (upd_raise) rd_n[IX_STAT][ST_IRQ] = 1'b1;
      rd_n[IX_INTR] = upd_intr;
      rd_n[IX_STEP] = upd_step;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        rd_q[i] <= reset_value(IXW'(i));
        wr_q[i] <= 8'h00;
      end
      rdata_q    <= 8'h00;
      cmd_stb_q  <= 1'b0;
      cmd_code_q <= 8'h00;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
      if (rd_ev) rdata_q <= pop_ev ? fifo_dout : rd_q[idx];
      cmd_stb_q <= wr_ev && (idx == IX_CMD);
      if (wr_ev && idx == IX_CMD) cmd_code_q <= wdata;
    end
  end

  assign rdata    = rdata_q;
  assign stat_irq = rd_q[IX_STAT][ST_IRQ];
  assign cmd_stb  = cmd_stb_q;
  assign cmd_code = cmd_code_q;
endmodule

// File: rtl/scsi_hostif.sv
module scsi_hostif
  import scsi_hostif_pkg::*;
#(
  parameter int AW         = 8,
  parameter int SW         = 2,
  parameter int FIFO_DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [SW-1:0] addr_shift,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq,
  output logic          fifo_overrun,
  output logic          cmd_stb,
  output logic [7:0]    cmd_code,
  input  logic          seq_upd,
  input  logic [6:0]    seq_status,
  input  logic [7:0]    seq_intr,
  input  logic [7:0]    seq_step,
  input  logic          seq_raise
);
  localparam int CW = $clog2(FIFO_DEPTH+1);

  logic [IXW-1:0] idx;
  logic           rd_ev, wr_ev, ev_pop, ev_ack, stat_irq;
  logic [7:0]     fifo_dout;
  logic [CW-1:0]  fifo_cnt;

  hostif_decode #(.AW(AW), .SW(SW)) u_dec (
    .bus_addr(bus_addr), .addr_shift(addr_shift),
    .rd_stb(rd_stb), .wr_stb(wr_stb),
    .idx(idx), .rd_ev(rd_ev), .wr_ev(wr_ev)
  );

  hostif_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_req(wr_ev && idx == IX_FIFO),
    .pop_req(rd_ev && idx == IX_FIFO),
    .din(wdata), .dout(fifo_dout), .cnt(fifo_cnt),
    .popped(ev_pop), .overrun(fifo_overrun)
  );

  hostif_regs u_regs (
    .clk(clk), .rst_n(rst_n), .idx(idx), .rd_ev(rd_ev), .wr_ev(wr_ev),
    .wdata(wdata), .pop_ev(ev_pop), .fifo_dout(fifo_dout),
    .upd_en(seq_upd), .upd_status(seq_status), .upd_intr(seq_intr),
    .upd_step(seq_step), .upd_raise(seq_raise),
    .rdata(rdata), .stat_irq(stat_irq), .ack_ev(ev_ack),
    .cmd_stb(cmd_stb), .cmd_code(cmd_code)
  );

  assign irq = stat_irq;
endmodule

// File: rtl/scsi_hostif_chk.sv
module scsi_hostif_chk #(
  parameter int CW    = 5,
  parameter int LIMIT = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic [7:0]    rdata,
  input logic          rd_ev,
  input logic          wr_ev,
  input logic [3:0]    idx,
  input logic          ev_pop,
  input logic          ev_ack,
  input logic [CW-1:0] fifo_cnt,
  input logic          fifo_overrun,
  input logic          cmd_stb,
  input logic          seq_upd,
  input logic          seq_raise
);
  assert_irq_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_pop || (seq_upd && seq_raise)));
  assert_irq_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(ev_ack));
  assert_ack_drops_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack && !(seq_upd && seq_raise)) |=> !irq);
  assert_pop_raises_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pop && !ev_ack) |=> irq);
  assert_fifo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(LIMIT));
  assert_overrun_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_overrun |-> ($past(wr_ev && idx == 4'd2 && fifo_cnt == CW'(LIMIT)) && $stable(fifo_cnt)));
  assert_cmd_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(wr_ev && idx == 4'd3));
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> $stable(rdata));
endmodule

bind scsi_hostif scsi_hostif_chk #(.CW(CW), .LIMIT(FIFO_DEPTH-1)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .rdata(rdata), .rd_ev(rd_ev),
  .wr_ev(wr_ev), .idx(idx), .ev_pop(ev_pop), .ev_ack(ev_ack),
  .fifo_cnt(fifo_cnt), .fifo_overrun(fifo_overrun), .cmd_stb(cmd_stb),
  .seq_upd(seq_upd), .seq_raise(seq_raise)
);

// File: tb/scsi_hostif_test.sv
`timescale 1ns/1ps
module scsi_hostif_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [1:0] addr_shift = '0;
  logic       rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, cmd_code;
  logic       irq, fifo_overrun, cmd_stb;
  logic       seq_upd = 1'b0, seq_raise = 1'b0;
  logic [6:0] seq_status = '0;
  logic [7:0] seq_intr = '0, seq_step = '0;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] m [16];
  logic [7:0] w [16];
  logic [7:0] q [$];

  always #4 clk = ~clk;

  scsi_hostif uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .addr_shift(addr_shift),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata), .irq(irq),
    .fifo_overrun(fifo_overrun), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .seq_upd(seq_upd), .seq_status(seq_status), .seq_intr(seq_intr),
    .seq_step(seq_step), .seq_raise(seq_raise)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] place(input int ix, input int s, input int junk);
    return 8'((ix << s) | (junk & ((1 << s) - 1)));
  endfunction

  function automatic logic echo_ix(input int ix);
    return (ix == 8) || (ix >= 11);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin m[i] = 8'h00; w[i] = 8'h00; end
    m[8] = 8'h07; m[14] = 8'h04;
    q.delete();
  endtask

  task automatic wr(input int ix, input logic [7:0] d, input int s = 0);
    logic exp_ovf;
    exp_ovf = 1'b0;
    w[ix] = d;
    if (ix == 0 || ix == 1) m[4][4] = 1'b0;
    if (ix == 2) begin
      if (q.size() == 15) exp_ovf = 1'b1; else q.push_back(d);
    end
    if (ix == 3) begin
      m[3] = d;
      if (d[7]) begin m[0] = w[0]; m[1] = w[1]; end
    end
    if (echo_ix(ix)) m[ix] = d;
    @(negedge clk);
    bus_addr = place(ix, s, $urandom); addr_shift = 2'(s); wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    if (ix == 2) chk("R5 overrun flag", 8'(fifo_overrun), 8'(exp_ovf));
    else         chk("R5 no overrun on non-FIFO write", 8'(fifo_overrun), 8'h00);
    chk("R9 cmd_stb", 8'(cmd_stb), 8'(ix == 3));
    if (ix == 3) chk("R9 cmd_code", cmd_code, d);
    chk("R11 irq follows status bit 7", 8'(irq), 8'(m[4][7]));
  endtask

  task automatic rd(input int ix, input string req, input int s = 0);
    logic [7:0] exp;
    exp = (ix == 2 && q.size() > 0) ? q[0] : m[ix];
    if (ix == 2 && q.size() > 0) begin m[2] = q.pop_front(); m[4][7] = 1'b1; end
    if (ix == 5) begin m[5] = 8'h00; m[4][4] = 1'b0; m[4][7] = 1'b0; m[6] = 8'h04; end
    @(negedge clk);
    bus_addr = place(ix, s, $urandom); addr_shift = 2'(s); rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk(req, rdata, exp);
    chk("R11 irq follows status bit 7", 8'(irq), 8'(m[4][7]));
  endtask

  task automatic upd(input logic [6:0] st, input logic [7:0] it, input logic [7:0] sp, input logic r);
    m[4][6:0] = st; if (r) m[4][7] = 1'b1; m[5] = it; m[6] = sp;
    @(negedge clk);
    seq_upd = 1'b1; seq_status = st; seq_intr = it; seq_step = sp; seq_raise = r;
    @(negedge clk);
    seq_upd = 1'b0; seq_raise = 1'b0;
    chk("R10 irq after update", 8'(irq), 8'(m[4][7]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset values (index 6 read before index 5)
    chk("R2 irq low after reset", 8'(irq), 8'h00);
    for (int i = 15; i >= 0; i--) rd(i, "R2 reset value");

    // R8: echo registers and write-only copies
    for (int i = 11; i <= 15; i++) wr(i, 8'(8'h30 + i));
    wr(8, 8'h5A);
    foreach (w[i]) if (echo_ix(i)) rd(i, "R8 read as written");
    wr(4, 8'hFF); wr(6, 8'hEE); wr(7, 8'hDD); wr(9, 8'hCC); wr(10, 8'hBB);
    rd(4, "R8 status ignores write"); rd(6, "R8 step ignores write");
    rd(7, "R8 index 7 ignores write"); rd(9, "R8 index 9 ignores write");
    rd(10, "R8 index 10 ignores write");

    // R10 / R3: sequencer update then acknowledge
    upd(7'h13, 8'h18, 8'h02, 1'b1);
    rd(4, "R10 status loaded"); rd(6, "R10 step loaded");
    rd(5, "R3 returns old interrupt value");
    rd(5, "R3 interrupt cleared");
    rd(4, "R3 status bit 4 and 7 cleared"); rd(6, "R3 step forced to 4");

    // R4: count write copies and reload
    upd(7'h10, 8'h00, 8'h00, 1'b0);
    wr(0, 8'h34); rd(4, "R4 count write clears bit 4");
    wr(1, 8'h12); rd(0, "R4 read copy unchanged"); rd(1, "R4 read copy unchanged");
    wr(3, 8'h10); rd(0, "R4 no reload without bit 7");
    wr(3, 8'h90); rd(0, "R4 reload low"); rd(1, "R4 reload mid");
    rd(3, "R9 command readable");

    // R5 / R6 / R7: fill, overrun, drain, empty pop
    for (int i = 0; i < 16; i++) wr(2, 8'(8'hA0 + i));
    for (int i = 0; i < 15; i++) rd(2, "R6 FIFO order");
    rd(5, "R3 acknowledge after pops");
    rd(2, "R7 empty pop returns last byte");
    rd(4, "R7 empty pop leaves status");
    for (int i = 0; i < 3; i++) wr(2, 8'(8'h60 + i));
    rd(2, "R7 order after drain and refill");

    // R1: stride decode
    wr(12, 8'h77, 2); rd(12, "R1 stride 2 decode", 2);
    wr(13, 8'h88, 3); rd(13, "R1 stride 3 decode", 3); rd(13, "R1 stride 1 reread", 1);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int op, ix, s;
      op = $urandom_range(0, 9);
      s  = $urandom_range(0, 3);
      ix = $urandom_range(0, 15);
      case (op)
        0, 1, 2: wr(2, 8'($urandom), s);
        3, 4:    rd(2, "R6 random FIFO pop", s);
        5:       wr(ix, 8'($urandom), s);
        6, 7:    rd(ix, "R1 random register read", s);
        8:       upd(7'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
        default: rd(5, "R3 random acknowledge", s);
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule